// File: doc/BRIEF.md
# Fractional Divider Tick Mux

This block picks one tick stream from a bank of single-cycle enable pulses and thins it by a programmable fixed-point ratio. The result is a single-cycle output pulse stream that paces one downstream peripheral. All streams are synchronous to one system clock. A tick is a one-cycle high level on the chosen input. The output has the same form.

Two 32-bit words program the block. The control word carries a source select in bits [3:0] and an enable in bit 4. Bit 7 of the control word is the position of a read-only busy flag, and the block ignores whatever is written there. The divide word holds an unsigned divisor with `FRAC_W` fraction bits and `INT_W` integer bits. The binary point sits fixed at bit 12, so the divisor occupies bits [12+INT_W-1 : 12-FRAC_W].

The ratio is realised with a first-order phase accumulator. Each selected tick adds 2^FRAC_W to the accumulator. Whenever the sum reaches the divisor, the block emits a pulse and subtracts the divisor. An instance built with both widths at zero has no divider and passes the chosen stream straight through.

Top module: `fracdiv_tick_mux`

## Requirements
- R1: While control bit 4 (enable) is 0, `tick_out` stays 0 one cycle later, whatever the inputs do.
- R2: `busy` equals control bit 4 as sampled at the previous clock edge. Writing control bit 7 has no effect on `busy`.
- R3: Select value 0 is a ground source: it never produces an output pulse, even when `src_tick[0]` is high.
- R4: A non-zero select value s makes `src_tick[s]` the only input that can cause output pulses.
- R5: The divisor is taken from divide-word bits [12+INT_W-1 : 12-FRAC_W]; all other divide-word bits are ignored.
- R6: With a divisor of zero the output stays silent.
- R7: Starting from a cleared accumulator with divisor D ≥ 2^FRAC_W, N selected ticks yield exactly floor(N·2^FRAC_W / D) output pulses.
- R8: An output pulse appears in the cycle after the selected input tick that brings the accumulator to or above the divisor. At most one pulse follows each input tick, and no pulse appears without one.
- R9: A change of the select field clears the accumulator and drops any tick sampled in that cycle.
- R10: Disabling the block clears the accumulator, so counting restarts from zero when it is enabled again.
- R11: With a divisor below 2^FRAC_W, every selected input tick produces an output pulse.
- R12: With INT_W = FRAC_W = 0, an enabled non-ground source passes through undivided, one cycle late.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_tick | input | N_SRC | Candidate tick streams, one bit per source |
| ctl_word | input | 32 | Control: [3:0] select, [4] enable, [7] busy position (ignored) |
| div_word | input | 32 | Fixed-point divisor, binary point at bit 12 |
| tick_out | output | 1 | Divided single-cycle tick pulse |
| busy | output | 1 | Running status, follows enable |

## Verification
A corrupted accumulator shows up at the ports as a pulse that arrives one or more input ticks early or late. It becomes visible within at most ceil(D/2^FRAC_W) selected ticks, because every pulse boundary exposes the stored phase. A select change or disable that fails to clear the phase is caught on the very next pulse after the event: the stale remainder moves that pulse forward. A wrong select decode or a leaking ground source is seen on the first cycle in which a non-selected input is high while the selected one is low. The tests drive exactly that noise pattern.

// File: rtl/fdm_pkg.sv
// Package: shared field positions of the fractional divider tick mux.
// Assumes 32-bit control and divide words with the binary point at bit 12.
package fdm_pkg;
    localparam int CTL_SEL_LSB  = 0;   // select field starts here
    localparam int CTL_SEL_MAXW = 4;   // room for up to 16 sources
    localparam int CTL_EN_BIT   = 4;   // enable
    localparam int CTL_BUSY_BIT = 7;   // read-only status position
    localparam int DIV_POINT    = 12;  // integer part starts at this bit
endpackage

// File: rtl/fdm_src_select.sv
// Module: picks one tick stream by index; index 0 and indices past the
// last source act as ground. Assumes N_SRC >= 2.
module fdm_src_select #(
    parameter int N_SRC = 16,
    parameter int SEL_W = 4
) (
    input  logic [N_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0] sel,
    output logic             sel_tick
);
    // Purpose: route the chosen source, forcing ground for index 0.
    always_comb begin
        sel_tick = 1'b0;
        if (sel != '0 && int'(sel) < N_SRC)
            sel_tick = src_tick[sel];
    end
endmodule

// File: rtl/fdm_phase_acc.sv
// Module: first-order phase accumulator. Each input tick adds 2^FRAC_W.
// A pulse is issued and the divisor removed once the sum reaches the
// divisor. Assumes DW = INT_W + FRAC_W >= 1; at most one pulse per tick.
module fdm_phase_acc #(
    parameter int INT_W  = 12,
    parameter int FRAC_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    restart,
    input  logic                    tick_in,
    input  logic [INT_W+FRAC_W-1:0] divisor,
    output logic                    pulse
);
    localparam int DW = INT_W + FRAC_W;
    localparam int AW = DW + 1;
    localparam logic [AW-1:0] STEP = AW'(1) << FRAC_W;

    logic [AW-1:0] acc_q, sum, rem, div_ext;
    logic          hit, live;

    // Purpose: form the next phase and decide whether this tick fires.
    always_comb begin
        div_ext = {1'b0, divisor};
        sum     = acc_q + STEP;
        rem     = sum - div_ext;
        live    = tick_in && (divisor != '0);
        hit     = live && (sum >= div_ext);
    end

    // Purpose: hold the phase and the registered output pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            pulse <= 1'b0;
        end else if (!en || restart) begin
            acc_q <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= hit;
            if (live)
                acc_q <= hit ? ((rem >= div_ext) ? '0 : rem) : sum;
        end
    end
endmodule

// File: rtl/fracdiv_tick_mux.sv
// Module: fractional divider tick mux top. Selects a tick source and
// divides it by a fixed-point ratio, or passes it through when both
// widths are zero. Assumes N_SRC <= 16, FRAC_W <= 12, INT_W <= 20.
module fracdiv_tick_mux
    import fdm_pkg::*;
#(
    parameter int N_SRC  = 16,
    parameter int INT_W  = 12,
    parameter int FRAC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_tick,
    input  logic [31:0]      ctl_word,
    input  logic [31:0]      div_word,
    output logic             tick_out,
    output logic             busy
);
    localparam int SEL_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam int DW      = INT_W + FRAC_W;
    localparam int DIV_LSB = DIV_POINT - FRAC_W;

    logic [SEL_W-1:0] sel, sel_q;
    logic             en, sel_tick, restart;
    logic             unused_bits;

    assign sel         = ctl_word[CTL_SEL_LSB +: SEL_W];
    assign en          = ctl_word[CTL_EN_BIT];
    assign restart     = (sel != sel_q);
    assign unused_bits = ^{ctl_word, div_word};

    fdm_src_select #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_select (
        .src_tick (src_tick),
        .sel      (sel),
        .sel_tick (sel_tick)
    );

    // Purpose: remember the last select and publish the enable state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            busy  <= 1'b0;
        end else begin
            sel_q <= sel;
            busy  <= en;
        end
    end

    generate
        if (DW == 0) begin : g_bypass
            logic pass_q;
            // Purpose: undivided, registered pass-through of the source.
            always_ff @(posedge clk) begin
                if (!rst_n) pass_q <= 1'b0;
                else        pass_q <= en && sel_tick;
            end
            assign tick_out = pass_q;
        end else begin : g_divide
            logic [DW-1:0] divisor;
            assign divisor = div_word[DIV_LSB +: DW];
            fdm_phase_acc #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_acc (
                .clk     (clk),
                .rst_n   (rst_n),
                .en      (en),
                .restart (restart),
                .tick_in (sel_tick),
                .divisor (divisor),
                .pulse   (tick_out)
            );
        end
    endgenerate
endmodule

// File: rtl/fdm_checker.sv
// Module: port-level properties of the fractional divider tick mux,
// attached to every instance by the bind below.
module fdm_checker
    import fdm_pkg::*;
#(
    parameter int N_SRC  = 16,
    parameter int INT_W  = 12,
    parameter int FRAC_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src_tick,
    input logic [31:0]      ctl_word,
    input logic [31:0]      div_word,
    input logic             tick_out,
    input logic             busy
);
    localparam int SEL_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam int DW      = INT_W + FRAC_W;
    localparam int DW_S    = (DW == 0) ? 1 : DW;
    localparam int DIV_LSB = DIV_POINT - FRAC_W;

    logic [SEL_W-1:0] c_sel;
    logic             c_en, c_tick;

    assign c_sel  = ctl_word[CTL_SEL_LSB +: SEL_W];
    assign c_en   = ctl_word[CTL_EN_BIT];
    assign c_tick = (c_sel != '0) && (int'(c_sel) < N_SRC) && src_tick[c_sel];

    p_silent_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !c_en |=> !tick_out);
    p_busy_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        c_en |=> busy);
    p_busy_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !c_en |=> !busy);
    p_ground_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_sel == '0) |=> !tick_out);
    p_needs_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !c_tick |=> !tick_out);

    generate
        if (DW == 0) begin : g_pass_chk
            p_pass_through_r12: assert property (@(posedge clk) disable iff (!rst_n)
                (c_en && c_tick) |=> tick_out);
        end else begin : g_div_chk
            logic [DW_S-1:0] c_div;
            assign c_div = div_word[DIV_LSB +: DW_S];
            p_zero_div_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (c_div == '0) |=> !tick_out);
        end
    endgenerate
endmodule

bind fracdiv_tick_mux fdm_checker #(
    .N_SRC(N_SRC), .INT_W(INT_W), .FRAC_W(FRAC_W)
) u_fdm_checker (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .ctl_word(ctl_word),
    .div_word(div_word), .tick_out(tick_out), .busy(busy)
);

// File: tb/test_fracdiv_tick_mux.sv
module test_fracdiv_tick_mux;
    localparam int NS  = 16;
    localparam int ONE = 4096;              // 2^FRAC_W at default widths
    localparam logic [31:0] EN = 32'h10;    // control bit 4

    typedef struct packed {
        logic [3:0]  sel;
        logic [31:0] dw;
        logic [7:0]  n;
    } vec_t;

    localparam vec_t VEC [0:8] = '{
        '{4'd1,  32'h0000_1000, 8'd10},  // R7 ratio 1
        '{4'd1,  32'h0000_2000, 8'd20},  // R7 ratio 2
        '{4'd2,  32'h0000_1800, 8'd30},  // R7 ratio 1.5
        '{4'd3,  32'h0000_3400, 8'd40},  // R7 ratio 3.25
        '{4'd5,  32'h0000_0800, 8'd8},   // R11 ratio 0.5
        '{4'd6,  32'h0000_0000, 8'd8},   // R6 zero divisor
        '{4'd15, 32'h0000_3000, 8'd9},   // R4 top source
        '{4'd4,  32'hFF00_2000, 8'd10},  // R5 stray high bits
        '{4'd0,  32'h0000_1000, 8'd10}   // R3 ground
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_tick = '0;
    logic [31:0]   ctl_word = '0;
    logic [31:0]   div_word = '0;
    logic          tick_out, busy, byp_out, byp_busy;
    int            n_chk = 0;
    int            n_err = 0;

    always #10 clk = ~clk;   // 50 MHz

    fracdiv_tick_mux #(.N_SRC(NS)) i_fracdiv_tick_mux (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .ctl_word(ctl_word),
        .div_word(div_word), .tick_out(tick_out), .busy(busy)
    );

    fracdiv_tick_mux #(.N_SRC(NS), .INT_W(0), .FRAC_W(0)) i_fracdiv_tick_mux_byp (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .ctl_word(ctl_word),
        .div_word(div_word), .tick_out(byp_out), .busy(byp_busy)
    );

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic cfg(input logic [31:0] c, input logic [31:0] d);
        @(negedge clk);
        ctl_word = c; div_word = d; src_tick = '0;
        @(posedge clk); #5;
    endtask

    task automatic cyc(input logic [NS-1:0] s, output logic t, output logic b);
        @(negedge clk);
        src_tick = s;
        @(posedge clk); #5;
        t = tick_out; b = byp_out;
    endtask

    initial begin
        #(20 * 150000);
        n_err++;
        $display("FAIL watchdog: got 0 expected 1 (run completed)");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic t, b;
        int   cnt, exp, d;
        // reset with active stimulus: outputs must stay low
        ctl_word = EN | 32'h1; div_word = 32'h1000; src_tick = '1;
        repeat (3) @(posedge clk);
        #5;
        check("reset tick_out", int'(tick_out), 0);
        check("reset busy", int'(busy), 0);
        @(negedge clk) rst_n = 1'b1;

        // table walk: rate, select, field position, ground, zero divisor
        foreach (VEC[i]) begin
            cfg('0, VEC[i].dw);
            cfg(EN | 32'(VEC[i].sel), VEC[i].dw);
            cnt = 0;
            for (int k = 0; k < int'(VEC[i].n); k++) begin
                cyc(NS'(1) << VEC[i].sel, t, b);
                cnt += int'(t);
                cyc(~(NS'(1) << VEC[i].sel), t, b);
                cnt += int'(t);
            end
            d = int'(VEC[i].dw[23:0]);
            if (VEC[i].sel == 0 || d == 0) exp = 0;
            else begin
                exp = (int'(VEC[i].n) * ONE) / d;
                if (exp > int'(VEC[i].n)) exp = int'(VEC[i].n);
            end
            check($sformatf("R7 table row %0d", i), cnt, exp);
        end

        // R8: pulse lands in the cycle after the tick that completes the phase
        cfg(EN | 32'h1, 32'h2000);
        cyc(16'h0002, t, b); check("R8 first tick no pulse", int'(t), 0);
        cyc(16'h0000, t, b); check("R8 idle no pulse", int'(t), 0);
        cyc(16'h0002, t, b); check("R8 second tick pulse", int'(t), 1);
        cyc(16'h0000, t, b); check("R8 single-cycle pulse", int'(t), 0);

        // R9: select change drops the half-built phase
        cyc(16'h0002, t, b);
        cfg(EN | 32'h2, 32'h2000);
        cyc(16'h0004, t, b); check("R9 phase cleared on select", int'(t), 0);
        cyc(16'h0004, t, b); check("R9 count restarts", int'(t), 1);

        // R10: disable clears the phase
        cyc(16'h0004, t, b);
        cfg(32'h2, 32'h2000);
        cfg(EN | 32'h2, 32'h2000);
        cyc(16'h0004, t, b); check("R10 phase cleared on disable", int'(t), 0);
        cyc(16'h0004, t, b); check("R10 count restarts", int'(t), 1);

        // R1: disabled block stays silent under ticks
        cfg(32'h1, 32'h1000);
        cnt = 0;
        for (int k = 0; k < 6; k++) begin
            cyc(16'hFFFF, t, b);
            cnt += int'(t);
        end
        check("R1 silent while disabled", cnt, 0);

        // R2: busy follows enable; bit 7 ignored
        cfg(EN | 32'h1, 32'h1000);
        check("R2 busy set", int'(busy), 1);
        cfg(32'h80 | 32'h1, 32'h1000);
        check("R2 busy bit write ignored", int'(busy), 0);

        // R12: pass-through instance
        cfg(EN | 32'h2, 32'h0);
        cyc(16'h0004, t, b);  check("R12 pass tick", int'(b), 1);
        cyc(16'hFFFB, t, b);  check("R12 other sources blocked", int'(b), 0);
        cyc(16'h0004, t, b);  check("R12 pass every tick", int'(b), 1);
        cfg(EN, 32'h0);
        cyc(16'hFFFF, t, b);  check("R12 ground blocked", int'(b), 0);
        cfg(32'h2, 32'h0);
        cyc(16'h0004, t, b);  check("R12 disabled blocked", int'(b), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule